// File: doc/BRIEF.md
# Vertical Format Table Loader

This block builds the vertical format table that a line printer's paper-motion logic consults. While a load function is active, an upstream fetch engine presents one byte per cycle with a valid strobe. The loader recognises framing bytes that open and close a table. It collects the 6-bit fragments that lie between them, joins each pair into one 12-bit entry and stores that entry at the next free slot. It reports the resulting table length, and a length of zero marks the table as unusable.

Other logic reads any entry through a combinational read port. The same logic steps a format pointer that wraps at the table length. A closing marker returns this pointer to the first line. A synchronous clear input wipes the whole table.

Top module: `vfl_loader`

## Requirements
- R1: After reset the table length is 0, `tbl_valid` is 0, the format pointer is 0 and every entry reads as 0.
- R2: An accepted byte of value 0xEC, 0xED or 0xEE (octal 354 to 356) is an opening marker: the length becomes 0 in the next cycle and the following data byte is taken as a low half.
- R3: In a table, a data byte's bits 5:0 are held as entry bits 5:0; the next data byte's bits 5:0 become entry bits 11:6. The entry is written at index equal to the current length, and the length rises by one in the cycle after the second byte.
- R4: An accepted byte 0xEF (octal 357) is a closing marker: the format pointer becomes 0 in the next cycle, and data bytes after it are ignored until the next opening marker.
- R5: A closing marker that arrives while a low half is waiting for its partner forces the length to 0.
- R6: An opening marker followed directly by a closing marker leaves the length at 0 and `tbl_valid` at 0.
- R7: The length never exceeds DEPTH. Pairs that complete while the length equals DEPTH are dropped and leave every stored entry unchanged.
- R8: Data bytes accepted before any opening marker change neither the length nor any entry.
- R9: `tbl_valid` is 1 exactly when the length is nonzero.
- R10: `clear` zeroes every entry, the length and the format pointer in the next cycle.
- R11: Bytes are accepted only while `load_active` is 1. Each rise of `load_active` returns the pairing logic to the before-opening state, so a held low half is discarded.
- R12: `ptr_step` advances the format pointer by one and wraps it to 0 after index length-1. It has no effect while the length is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Synchronous wipe of the table, length and pointer |
| load_active | input | 1 | Load function in progress |
| byte_vld | input | 1 | `byte_in` carries a byte this cycle |
| byte_in | input | 8 | Stream byte |
| ptr_step | input | 1 | Advance the format pointer by one line |
| rd_addr | input | AW | Entry index to read |
| rd_data | output | 12 | Entry at `rd_addr` (0 beyond DEPTH-1) |
| tbl_len | output | AW | Number of stored entries |
| tbl_valid | output | 1 | Table length is nonzero |
| fmt_ptr | output | AW | Current format pointer |

## Verification
The bench builds the loader with its default depth of 143 entries and the default marker values. This keeps the full-table case cheap to reach: 286 data bytes fill the table, and one further pair then tests the drop rule at the real capacity. The defaults also let the marker ranges be checked against the exact byte values used by the stream format. The pointer wrap is exercised on a two-entry table, and the load-function restart is exercised with a low half held across the restart.

// File: rtl/vfl_pkg.sv
// Package vfl_pkg
// Shared types for the vertical format table loader: byte classes and
// the pairing phase. Assumes nothing beyond IEEE 1800-2017.
package vfl_pkg;

    // Class of an incoming stream byte
    typedef enum logic [1:0] {
        BK_DATA  = 2'd0,
        BK_OPEN  = 2'd1,
        BK_CLOSE = 2'd2
    } byte_kind_t;

    // Pairing phase of the fragment assembler
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // no opening marker seen yet
        PH_LOW  = 2'd1,   // next data byte is a low half
        PH_HIGH = 2'd2    // low half held, next data byte completes entry
    } pair_phase_t;

endpackage

// File: rtl/vfl_classify.sv
// Module vfl_classify
// Sorts a stream byte into data, opening marker or closing marker and
// extracts its data fragment. Purely combinational. Assumes
// OPEN_LO <= OPEN_HI and that CLOSE lies outside that range.
module vfl_classify #(
    parameter int BYTE_W          = 8,
    parameter int FRAG_W          = 6,
    parameter logic [7:0] OPEN_LO = 8'hEC,
    parameter logic [7:0] OPEN_HI = 8'hEE,
    parameter logic [7:0] CLOSE   = 8'hEF
) (
    input  logic [BYTE_W-1:0]      byte_in,
    output vfl_pkg::byte_kind_t    kind,
    output logic [FRAG_W-1:0]      frag
);
    import vfl_pkg::*;

    // Decide the byte class from the marker values
    always_comb begin
        if (byte_in >= OPEN_LO && byte_in <= OPEN_HI) begin
            kind = BK_OPEN;
        end else if (byte_in == CLOSE) begin
            kind = BK_CLOSE;
        end else begin
            kind = BK_DATA;
        end
    end

    // The fragment is always the low bits of the byte
    assign frag = byte_in[FRAG_W-1:0];

endmodule

// File: rtl/vfl_pairer.sv
// Module vfl_pairer
// Tracks the pairing phase, holds the low-half fragment and issues a
// write of an assembled entry when the high half arrives. Also emits
// one-cycle pulses for opening and closing markers. Assumes bytes only
// count while load_active is high; a rise of load_active restarts the
// phase at PH_IDLE in the same cycle.
module vfl_pairer #(
    parameter int FRAG_W  = 6,
    parameter int ENTRY_W = 2 * FRAG_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                load_active,
    input  logic                byte_vld,
    input  vfl_pkg::byte_kind_t kind,
    input  logic [FRAG_W-1:0]   frag,
    output logic                wr_en,
    output logic [ENTRY_W-1:0]  wr_entry,
    output logic                open_p,
    output logic                close_p,
    output logic                close_odd_p
);
    import vfl_pkg::*;

    pair_phase_t         phase_q;
    pair_phase_t         phase_eff;
    pair_phase_t         phase_d;
    logic [FRAG_W-1:0]   low_q;
    logic                load_q;
    logic                accept;
    logic                load_rise;

    // Remember the previous load_active level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q <= 1'b0;
        end else begin
            load_q <= load_active;
        end
    end

    assign load_rise = load_active && !load_q;
    assign accept    = load_active && byte_vld;

    // Phase seen by this cycle's byte: a new load function starts fresh
    always_comb begin
        phase_eff = load_rise ? PH_IDLE : phase_q;
    end

    // Decode the byte into event pulses
    always_comb begin
        open_p      = accept && (kind == BK_OPEN);
        close_p     = accept && (kind == BK_CLOSE);
        close_odd_p = close_p && (phase_eff == PH_HIGH);
        wr_en       = accept && (kind == BK_DATA) && (phase_eff == PH_HIGH);
        wr_entry    = {frag, low_q};
    end

    // Next pairing phase
    always_comb begin
        phase_d = phase_eff;
        if (clear) begin
            phase_d = PH_IDLE;
        end else if (open_p) begin
            phase_d = PH_LOW;
        end else if (close_p) begin
            phase_d = PH_IDLE;
        end else if (accept && kind == BK_DATA) begin
            case (phase_eff)
                PH_LOW:  phase_d = PH_HIGH;
                PH_HIGH: phase_d = PH_LOW;
                default: phase_d = PH_IDLE;
            endcase
        end
    end

    // Register the phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Capture the low-half fragment in the low phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q <= '0;
        end else if (accept && kind == BK_DATA && phase_eff == PH_LOW) begin
            low_q <= frag;
        end
    end

endmodule

// File: rtl/vfl_table.sv
// Module vfl_table
// Entry storage of DEPTH words, one register per entry built by a
// generate loop so that a clear wipes all of them in one cycle.
// Read is combinational; addresses past DEPTH-1 read as zero.
// Assumes wr_idx < DEPTH whenever wr_en is high.
module vfl_table #(
    parameter int DEPTH   = 143,
    parameter int ENTRY_W = 12,
    parameter int AW      = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_idx,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic [AW-1:0]      rd_addr,
    output logic [ENTRY_W-1:0] rd_data
);
    logic [ENTRY_W-1:0] mem_q [DEPTH];

    // One storage register per entry
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        localparam logic [AW-1:0] IDX = AW'(g);
        // Write or wipe entry g
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                mem_q[g] <= '0;
            end else if (wr_en && wr_idx == IDX) begin
                mem_q[g] <= wr_data;
            end
        end
    end

    // Read mux with out-of-range guard
    always_comb begin
        rd_data = '0;
        if (int'(rd_addr) < DEPTH) begin
            rd_data = mem_q[rd_addr];
        end
    end

endmodule

// File: rtl/vfl_loader.sv
// Module vfl_loader
// Top of the vertical format table loader. Classifies stream bytes,
// pairs fragments into entries, stores them, and keeps the table length
// and the format pointer. Assumes the stream source only presents bytes
// while load_active is high; bytes at other times are ignored.
module vfl_loader #(
    parameter int DEPTH           = 143,
    parameter int FRAG_W          = 6,
    parameter int BYTE_W          = 8,
    parameter logic [7:0] OPEN_LO = 8'hEC,
    parameter logic [7:0] OPEN_HI = 8'hEE,
    parameter logic [7:0] CLOSE   = 8'hEF,
    localparam int ENTRY_W        = 2 * FRAG_W,
    localparam int AW             = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               load_active,
    input  logic               byte_vld,
    input  logic [BYTE_W-1:0]  byte_in,
    input  logic               ptr_step,
    input  logic [AW-1:0]      rd_addr,
    output logic [ENTRY_W-1:0] rd_data,
    output logic [AW-1:0]      tbl_len,
    output logic               tbl_valid,
    output logic [AW-1:0]      fmt_ptr
);
    import vfl_pkg::*;

    localparam logic [AW-1:0] FULL_LEN = AW'(DEPTH);

    byte_kind_t          kind;
    logic [FRAG_W-1:0]   frag;
    logic                pair_wr;
    logic [ENTRY_W-1:0]  pair_entry;
    logic                open_p;
    logic                close_p;
    logic                close_odd_p;
    logic                store_wr;
    logic [AW-1:0]       len_q;
    logic [AW-1:0]       ptr_q;

    vfl_classify #(
        .BYTE_W  (BYTE_W),
        .FRAG_W  (FRAG_W),
        .OPEN_LO (OPEN_LO),
        .OPEN_HI (OPEN_HI),
        .CLOSE   (CLOSE)
    ) u_classify (
        .byte_in (byte_in),
        .kind    (kind),
        .frag    (frag)
    );

    vfl_pairer #(
        .FRAG_W  (FRAG_W),
        .ENTRY_W (ENTRY_W)
    ) u_pairer (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (clear),
        .load_active (load_active),
        .byte_vld    (byte_vld),
        .kind        (kind),
        .frag        (frag),
        .wr_en       (pair_wr),
        .wr_entry    (pair_entry),
        .open_p      (open_p),
        .close_p     (close_p),
        .close_odd_p (close_odd_p)
    );

    // A completed pair is stored only while there is room
    assign store_wr = pair_wr && (len_q < FULL_LEN);

    vfl_table #(
        .DEPTH   (DEPTH),
        .ENTRY_W (ENTRY_W),
        .AW      (AW)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .wr_en   (store_wr),
        .wr_idx  (len_q),
        .wr_data (pair_entry),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // Table length: zeroed by clear, opening or unpaired close; grows per stored pair
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            len_q <= '0;
        end else if (open_p || close_odd_p) begin
            len_q <= '0;
        end else if (store_wr) begin
            len_q <= len_q + 1'b1;
        end
    end

    // Format pointer: zeroed by clear or close, stepped with wrap at the length
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ptr_q <= '0;
        end else if (close_p) begin
            ptr_q <= '0;
        end else if (ptr_step && len_q != '0) begin
            if (ptr_q + 1'b1 >= len_q) begin
                ptr_q <= '0;
            end else begin
                ptr_q <= ptr_q + 1'b1;
            end
        end
    end

    assign tbl_len   = len_q;
    assign tbl_valid = (len_q != '0);
    assign fmt_ptr   = ptr_q;

endmodule

// File: rtl/vfl_loader_chk.sv
// Module vfl_loader_chk
// Temporal checks on the loader's ports, bound to every vfl_loader
// instance. Assumes the same parameters as the bound instance.
module vfl_loader_chk #(
    parameter int DEPTH           = 143,
    parameter logic [7:0] OPEN_LO = 8'hEC,
    parameter logic [7:0] OPEN_HI = 8'hEE,
    parameter logic [7:0] CLOSE   = 8'hEF,
    parameter int AW              = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clear,
    input logic          load_active,
    input logic          byte_vld,
    input logic [7:0]    byte_in,
    input logic [AW-1:0] tbl_len,
    input logic          tbl_valid,
    input logic [AW-1:0] fmt_ptr
);
    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(tbl_len) <= DEPTH); // R7

    AST_OPEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (load_active && byte_vld && byte_in >= OPEN_LO && byte_in <= OPEN_HI)
        |=> (tbl_len == '0) && !tbl_valid); // R2

    AST_CLOSE_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (load_active && byte_vld && byte_in == CLOSE) |=> (fmt_ptr == '0)); // R4

    AST_LEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (tbl_len == $past(tbl_len)) || (tbl_len == $past(tbl_len) + 1'b1)
                   || (tbl_len == '0)); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_active && !clear) |=> $stable(tbl_len)); // R11

    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (tbl_len == '0) && (fmt_ptr == '0)); // R10

endmodule

bind vfl_loader vfl_loader_chk #(
    .DEPTH   (DEPTH),
    .OPEN_LO (OPEN_LO),
    .OPEN_HI (OPEN_HI),
    .CLOSE   (CLOSE),
    .AW      (AW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (clear),
    .load_active (load_active),
    .byte_vld    (byte_vld),
    .byte_in     (byte_in),
    .tbl_len     (tbl_len),
    .tbl_valid   (tbl_valid),
    .fmt_ptr     (fmt_ptr)
);

// File: tb/vfl_loader_tb.sv
// Self-checking bench for vfl_loader: a vector table walk, then
// directed tests for reset, framing faults, capacity, clear, restart
// of the load function and pointer stepping.
module vfl_loader_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 143;
    localparam int AW         = $clog2(DEPTH + 1);
    localparam int NVEC       = 12;

    // Vector: {byte_vld, byte, expected length after the byte}
    localparam logic [16:0] VEC [NVEC] = '{
        {1'b1, 8'o025, 8'd0},   // R8 data before any opening
        {1'b1, 8'o354, 8'd0},   // R2 opening
        {1'b1, 8'o101, 8'd0},   // R3 low half
        {1'b1, 8'o077, 8'd1},   // R3 high half
        {1'b1, 8'o355, 8'd0},   // R2 reopen
        {1'b1, 8'o012, 8'd0},
        {1'b1, 8'o034, 8'd1},
        {1'b1, 8'o345, 8'd1},
        {1'b1, 8'o216, 8'd2},
        {1'b1, 8'o357, 8'd2},   // R4 close
        {1'b1, 8'o011, 8'd2},   // R4 ignored after close
        {1'b1, 8'o011, 8'd2}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clear = 1'b0;
    logic          load_active = 1'b0;
    logic          byte_vld = 1'b0;
    logic [7:0]    byte_in = '0;
    logic          ptr_step = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [11:0]   rd_data;
    logic [AW-1:0] tbl_len;
    logic          tbl_valid;
    logic [AW-1:0] fmt_ptr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    vfl_loader #(.DEPTH(DEPTH)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (clear),
        .load_active (load_active),
        .byte_vld    (byte_vld),
        .byte_in     (byte_in),
        .ptr_step    (ptr_step),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .tbl_len     (tbl_len),
        .tbl_valid   (tbl_valid),
        .fmt_ptr     (fmt_ptr)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Present one byte for one cycle; results are visible on return
    task automatic push(input logic [7:0] b);
        byte_vld = 1'b1;
        byte_in  = b;
        @(negedge clk);
        byte_vld = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic step_ptr();
        ptr_step = 1'b1;
        @(negedge clk);
        ptr_step = 1'b0;
    endtask

    task automatic read_entry(input int idx, output int val);
        rd_addr = AW'(idx);
        #1;
        val = int'(rd_data);
    endtask

    task automatic do_clear();
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int v;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 len", int'(tbl_len), 0);
        check("R1 valid", int'(tbl_valid), 0);
        check("R1 ptr", int'(fmt_ptr), 0);
        read_entry(0, v);
        check("R1 entry0", v, 0);

        // Vector table walk
        load_active = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NVEC; i++) begin
            push(VEC[i][15:8]);
            check($sformatf("R3 vec%0d len", i), int'(tbl_len), int'(VEC[i][7:0]));
            check($sformatf("R9 vec%0d valid", i), int'(tbl_valid), int'(VEC[i][7:0] != 0));
        end
        read_entry(0, v);
        check("R3 entry0", v, 12'o3412);
        read_entry(1, v);
        check("R3 entry1", v, 12'o1645);
        check("R4 ptr after close", int'(fmt_ptr), 0);

        // R12 pointer stepping on a two-entry table
        step_ptr();
        check("R12 ptr step1", int'(fmt_ptr), 1);
        step_ptr();
        check("R12 ptr wrap", int'(fmt_ptr), 0);
        step_ptr();
        check("R12 ptr step again", int'(fmt_ptr), 1);
        push(8'o357);
        check("R4 close resets ptr", int'(fmt_ptr), 0);

        // R5 close with unpaired low half
        push(8'o354);
        push(8'o005);
        push(8'o006);
        check("R5 len before", int'(tbl_len), 1);
        push(8'o007);
        push(8'o357);
        check("R5 len forced zero", int'(tbl_len), 0);
        check("R5 valid", int'(tbl_valid), 0);

        // R6 empty frame
        push(8'o356);
        push(8'o357);
        check("R6 len", int'(tbl_len), 0);
        check("R6 valid", int'(tbl_valid), 0);

        // R12 no step effect while length is zero
        step_ptr();
        check("R12 ptr held at len0", int'(fmt_ptr), 0);

        // R11 bytes ignored while load inactive
        push(8'o354);
        push(8'o001);
        push(8'o002);
        check("R11 pre len", int'(tbl_len), 1);
        load_active = 1'b0;
        push(8'o354);
        push(8'o003);
        check("R11 inactive ignored", int'(tbl_len), 1);
        // R11 restart discards held low half and needs a new opening
        load_active = 1'b1;
        push(8'o354);
        push(8'o003);
        load_active = 1'b0;
        @(negedge clk);
        load_active = 1'b1;
        push(8'o004);
        push(8'o005);
        check("R11 restart ignored", int'(tbl_len), 0);
        push(8'o355);
        push(8'o021);
        push(8'o042);
        check("R11 after reopen", int'(tbl_len), 1);
        read_entry(0, v);
        check("R11 entry0", v, 12'o4221);

        // R10 clear
        do_clear();
        check("R10 len", int'(tbl_len), 0);
        check("R10 ptr", int'(fmt_ptr), 0);
        read_entry(0, v);
        check("R10 entry0", v, 0);

        // R8 data before opening after clear
        push(8'o011);
        push(8'o022);
        check("R8 len", int'(tbl_len), 0);
        read_entry(0, v);
        check("R8 entry0", v, 0);

        // R7 fill to capacity, then one extra pair is dropped
        push(8'o354);
        for (int k = 0; k < DEPTH; k++) begin
            push(8'(k % 64));
            push(8'(63 - (k % 64)));
        end
        check("R7 full len", int'(tbl_len), DEPTH);
        push(8'o070);
        push(8'o070);
        check("R7 len held", int'(tbl_len), DEPTH);
        read_entry(DEPTH - 1, v);
        check("R7 last entry", v, ((63 - ((DEPTH - 1) % 64)) << 6) | ((DEPTH - 1) % 64));
        read_entry(0, v);
        check("R7 first entry", v, 63 << 6);

        // R1 reset again clears the table
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 len after reset", int'(tbl_len), 0);
        read_entry(0, v);
        check("R1 entry0 after reset", v, 0);

        idle(2);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule